// File: doc/BRIEF.md
# Jack Sense Interrupt Controller

This block watches two jack-detect inputs and turns their activity into readable level bits, sticky interrupt flags, one combined level interrupt and an EQ-bypass request. Each input crosses into the clock domain through its own two-flop synchronizer. It then passes through a qualifier that can require the input to stay high for more than a set time, 278 ms by default, before the high level counts. That qualified level is the "recognized" level used by the rest of the block.

Software sees one 16-bit control/status word. It writes the word with a single-cycle strobe and reads it back on a combinational read port. For each pin the word holds an interrupt flag, a live level bit, a mode bit, a qualifier-enable bit and an EQ-bypass-enable bit. It also holds a 3-bit mute-select field that is only stored. When a pin is in interrupt mode, a rising edge of its recognized level sets its flag. When the pin is in jack-sense mode, the pin raises nothing. Software clears a flag by writing 0 to it and can raise an interrupt by writing 1.

Top module: `jack_sense_ctl`

## Requirements
- R1: Word layout: bit 0 flag A, bit 1 flag B, bit 2 level A, bit 3 level B, bit 4 mode A, bit 5 mode B, bit 6 qualifier-enable A, bit 7 qualifier-enable B, bit 8 bypass-enable A, bit 9 bypass-enable B, bits 12:10 mute select, bits 15:13 read 0. A write stores every writable field, and the next read returns the stored value.
- R2: A set flag stays set until a write puts 0 in its bit.
- R3: A write with 1 in a flag bit sets that flag in the next cycle, which raises an interrupt from software.
- R4: `irq` is high exactly when at least one flag is set.
- R5: Each level bit shows its pin after two clock edges of synchronization. Writes to the level bits have no effect.
- R6: With the qualifier off and mode = 1 (interrupt mode), a pin that rises before edge n sets its flag at edge n+2. With mode = 0 (jack-sense mode, the reset default), the pin never sets its flag.
- R7: With the qualifier enabled, the recognized level goes high only after the synchronized pin has been high for more than QUAL_CYCLES = CLK_KHZ*QUAL_MS cycles. Any low cycle restarts the count.
- R8: `eq_bypass` is high when, for some pin, bypass-enable is 1 and that pin's recognized level is high.
- R9: When a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R10: After reset every stored bit is 0, so `rd_data`, `irq` and `eq_bypass` are 0 while the pins are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| jack_in | input | 2 | Jack-detect inputs, bit 0 pin A, bit 1 pin B (asynchronous) |
| wr_en | input | 1 | One-cycle write strobe for the control/status word |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current control/status word |
| irq | output | 1 | Level interrupt, OR of the two flags |
| eq_bypass | output | 1 | EQ-bypass request |

## Verification
The main function is first tried with directed pin edges. A plain rising edge separates interrupt mode from jack-sense mode. A pin held high across the qualification window shows where the count ends, off by one cycle either way. A pulse that drops for a single cycle mid-window shows whether the counter restarts. A write that clears a flag in the same cycle as the hardware sets it shows which one has priority. After that, a long stretch of sparse random pin toggles and random register writes runs against a reference model in the bench. This exposes mixed timer/mode combinations, interplay between the two pins, and readback of every field.

// File: rtl/jsc_pkg.sv
package jsc_pkg;
    localparam int NPIN  = 2;
    localparam int REG_W = 16;
    localparam int MUTE_W = 3;

    // bit positions of the control/status word
    localparam int POS_FLAG = 0;
    localparam int POS_LVL  = 2;
    localparam int POS_MODE = 4;
    localparam int POS_TMR  = 6;
    localparam int POS_BYP  = 8;
    localparam int POS_MUTE = 10;

    typedef struct packed {
        logic [NPIN-1:0]   flag;
        logic [NPIN-1:0]   mode;
        logic [NPIN-1:0]   tmr;
        logic [NPIN-1:0]   byp;
        logic [MUTE_W-1:0] mute;
    } ctl_regs_t;
endpackage

// File: rtl/jsc_sync.sv
module jsc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/jsc_qual.sv
module jsc_qual #(
    parameter int CNT_MAX = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic tmr_en_i,
    output logic qual_o,
    output logic rise_o
);
    localparam int CW = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          qual;
    } qual_st_t;

    qual_st_t st_d, st_q;
    logic     at_max;

    always_comb begin
        st_d   = st_q;
        at_max = (st_q.cnt == CW'(CNT_MAX));
        if (!lvl_i)       st_d.cnt = '0;
        else if (!at_max) st_d.cnt = st_q.cnt + 1'b1;
        st_d.qual = lvl_i && (tmr_en_i ? at_max : 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign qual_o = st_q.qual;
    assign rise_o = st_d.qual & ~st_q.qual;

    logic [CW-1:0] cnt_q;
    assign cnt_q = st_q.cnt;

    AST_QUAL_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qual_o) && $past(tmr_en_i) |-> $past(cnt_q) == CW'(CNT_MAX)); // R7
    AST_QUAL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_i |=> !qual_o); // R7
endmodule

// File: rtl/jack_sense_ctl.sv
module jack_sense_ctl
    import jsc_pkg::*;
#(
    parameter int CLK_KHZ = 125000,
    parameter int QUAL_MS = 278
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  jack_in,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        irq,
    output logic        eq_bypass
);
    localparam int QUAL_CYCLES = CLK_KHZ * QUAL_MS;

    ctl_regs_t       reg_d, reg_q;
    logic [NPIN-1:0] lvl_sync;
    logic [NPIN-1:0] lvl_qual;
    logic [NPIN-1:0] lvl_rise;
    logic [NPIN-1:0] hw_set;

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        jsc_sync #(.STAGES(2)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (jack_in[i]),
            .dout (lvl_sync[i])
        );
        jsc_qual #(.CNT_MAX(QUAL_CYCLES)) u_qual (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl_i   (lvl_sync[i]),
            .tmr_en_i(reg_q.tmr[i]),
            .qual_o  (lvl_qual[i]),
            .rise_o  (lvl_rise[i])
        );
    end

    always_comb begin
        hw_set = lvl_rise & reg_q.mode;
        reg_d  = reg_q;
        if (wr_en) begin
            reg_d.flag = wr_data[POS_FLAG +: NPIN];
            reg_d.mode = wr_data[POS_MODE +: NPIN];
            reg_d.tmr  = wr_data[POS_TMR  +: NPIN];
            reg_d.byp  = wr_data[POS_BYP  +: NPIN];
            reg_d.mute = wr_data[POS_MUTE +: MUTE_W];
        end
        reg_d.flag = reg_d.flag | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    always_comb begin
        rd_data = '0;
        rd_data[POS_FLAG +: NPIN]   = reg_q.flag;
        rd_data[POS_LVL  +: NPIN]   = lvl_sync;
        rd_data[POS_MODE +: NPIN]   = reg_q.mode;
        rd_data[POS_TMR  +: NPIN]   = reg_q.tmr;
        rd_data[POS_BYP  +: NPIN]   = reg_q.byp;
        rd_data[POS_MUTE +: MUTE_W] = reg_q.mute;
    end

    assign irq       = |reg_q.flag;
    assign eq_bypass = |(reg_q.byp & lvl_qual);

    logic [NPIN-1:0] flag_q, mode_q;
    assign flag_q = reg_q.flag;
    assign mode_q = reg_q.mode;

    for (genvar i = 0; i < NPIN; i++) begin : g_chk
        AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            flag_q[i] && !(wr_en && !wr_data[i]) |=> flag_q[i]); // R2
        AST_FLAG_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag_q[i]) |-> $past(wr_en && !wr_data[i])); // R2
        AST_FLAG_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q[i]) |-> $past(wr_en && wr_data[i]) || $past(lvl_rise[i] && mode_q[i])); // R3
        AST_JACK_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !mode_q[i] && !flag_q[i] && !(wr_en && wr_data[i]) |=> !flag_q[i]); // R6
        AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            lvl_rise[i] && mode_q[i] |=> flag_q[i]); // R9
    end

    AST_EQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        eq_bypass |-> |reg_q.byp); // R8
    AST_IRQ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wr_en) || $past(|(lvl_rise & mode_q))); // R4
endmodule

// File: tb/tb_jack_sense_ctl.sv
module tb_jack_sense_ctl;
    localparam int CLK_KHZ = 1;
    localparam int QUAL_MS = 20;
    localparam int Q = CLK_KHZ * QUAL_MS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  jack_in = 2'b00;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        irq;
    logic        eq_bypass;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;   // 125 MHz

    jack_sense_ctl #(.CLK_KHZ(CLK_KHZ), .QUAL_MS(QUAL_MS)) dut (
        .clk(clk), .rst_n(rst_n), .jack_in(jack_in), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .eq_bypass(eq_bypass)
    );

    // reference model built from the requirements
    logic [1:0] m_s1, m_s2, m_qual, m_flag, m_mode, m_tmr, m_byp;
    logic [2:0] m_mute;
    int         m_cnt [2];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_qual <= '0; m_flag <= '0;
            m_mode <= '0; m_tmr <= '0; m_byp <= '0; m_mute <= '0;
            m_cnt[0] <= 0; m_cnt[1] <= 0;
        end else begin
            logic [1:0] nq;
            logic [1:0] nf;
            nf = wr_en ? wr_data[1:0] : m_flag;
            for (int i = 0; i < 2; i++) begin
                nq[i] = m_s2[i] && (m_tmr[i] ? (m_cnt[i] == Q) : 1'b1);
                if (nq[i] && !m_qual[i] && m_mode[i]) nf[i] = 1'b1;
                if (!m_s2[i]) m_cnt[i] <= 0;
                else if (m_cnt[i] != Q) m_cnt[i] <= m_cnt[i] + 1;
            end
            m_s1 <= jack_in;
            m_s2 <= m_s1;
            m_qual <= nq;
            m_flag <= nf;
            if (wr_en) begin
                m_mode <= wr_data[5:4];
                m_tmr  <= wr_data[7:6];
                m_byp  <= wr_data[9:8];
                m_mute <= wr_data[12:10];
            end
        end
    end

    function automatic logic [15:0] exp_word();
        return {3'b000, m_mute, m_byp, m_tmr, m_mode, m_s2, m_flag};
    endfunction

    function automatic logic exp_eq();
        return |(m_byp & m_qual);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 rd_data", rd_data, 16'h0000);
        chk("R10 irq", {15'b0, irq}, 16'h0);
        chk("R10 eq_bypass", {15'b0, eq_bypass}, 16'h0);

        // R1 full write and readback; R3 flags set by software; R4 irq
        wr(16'hFFFF);
        chk("R1 readback all-ones", rd_data, 16'h1FF3);
        chk("R4 irq with flags", {15'b0, irq}, 16'h1);
        wr(16'h0000);
        chk("R2 cleared by 0", rd_data, 16'h0000);
        chk("R4 irq idle", {15'b0, irq}, 16'h0);
        wr(16'h0002);
        chk("R3 sw set flag B", rd_data, 16'h0002);
        chk("R4 irq from flag B", {15'b0, irq}, 16'h1);
        settle(5);
        chk("R2 flag B sticky", rd_data, 16'h0002);
        wr(16'h0000);
        // R5 level bits not writable
        wr(16'h000C);
        chk("R5 level bits ignore write", rd_data, 16'h0000);

        // R5 level latency, R6 jack-sense mode sets nothing
        jack_in[0] = 1'b1;
        @(negedge clk);
        chk("R5 level after 1 edge", rd_data, 16'h0000);
        @(negedge clk);
        chk("R5 level after 2 edges", rd_data, 16'h0004);
        settle(4);
        chk("R6 jack mode no flag", {15'b0, irq}, 16'h0);
        jack_in[0] = 1'b0;
        settle(4);

        // R6 interrupt mode, R8 bypass, no qualifier
        wr(16'h0110);
        jack_in[0] = 1'b1;
        settle(2);
        chk("R6 flag not yet", {15'b0, irq}, 16'h0);
        chk("R8 eq not yet", {15'b0, eq_bypass}, 16'h0);
        @(negedge clk);
        chk("R6 flag at edge n+2", {15'b0, irq}, 16'h1);
        chk("R8 eq on recognized level", {15'b0, eq_bypass}, 16'h1);
        jack_in[0] = 1'b0;
        settle(4);
        chk("R8 eq follows pin low", {15'b0, eq_bypass}, 16'h0);

        // R9 hardware set beats software clear
        wr(16'h0110);
        chk("R2 flag cleared", {15'b0, irq}, 16'h0);
        jack_in[0] = 1'b1;
        settle(2);
        wr_en = 1'b1; wr_data = 16'h0110;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        chk("R9 hw set wins", rd_data & 16'h0003, 16'h0001);
        jack_in[0] = 1'b0;
        settle(4);

        // R7 qualifier: exact window
        wr(16'h0050);
        jack_in[0] = 1'b1;
        settle(Q + 2);
        chk("R7 not before window", {15'b0, irq}, 16'h0);
        @(negedge clk);
        chk("R7 recognized after window", {15'b0, irq}, 16'h1);
        jack_in[0] = 1'b0;
        settle(4);
        wr(16'h0050);

        // R7 a one-cycle low restarts the count
        jack_in[0] = 1'b1;
        settle(Q);
        jack_in[0] = 1'b0;
        @(negedge clk);
        jack_in[0] = 1'b1;
        settle(Q + 2);
        chk("R7 restart after glitch", {15'b0, irq}, 16'h0);
        @(negedge clk);
        chk("R7 recognized after restart", {15'b0, irq}, 16'h1);

        // random phase against the reference model
        for (int c = 0; c < 6000; c++) begin
            chk("R1 word vs model", rd_data, exp_word());
            chk("R4 irq vs model", {15'b0, irq}, {15'b0, |m_flag});
            chk("R8 eq vs model", {15'b0, eq_bypass}, {15'b0, exp_eq()});
            wr_en = 1'b0;
            for (int p = 0; p < 2; p++)
                if ($urandom_range(0, 15) == 0) jack_in[p] = ~jack_in[p];
            if ($urandom_range(0, 23) == 0) begin
                wr_en = 1'b1;
                wr_data = 16'($urandom);
            end
            @(negedge clk);
        end
        wr_en = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule